// File: doc/BRIEF.md
# Clock Generator Power-Down and Strap Controller

This block sits between the synthesized clock dividers of a multi-output clock generator and its output buffers. It takes one active-low power-down request that arrives asynchronously and brings it through a synchronizer. While the request is held it parks each output clock group low, and it does so only in that group's own low phase. Once every group is quiet it turns off the oscillator and PLL enables. When the request is released it turns the oscillator and PLL back on and waits a programmable restart interval, counted on the free-running reference clock, before outputs may toggle again. A new request during that wait cancels the restart.

At power-up the two reference-clock pads are first used as inputs. After a fixed sampling window the block latches an APIC speed strap and a test-mode strap from them, and from then on the pads drive the reference clock. A width-select input decides whether the two upper CPU outputs and the two upper APIC outputs run. It is read at power-up and still followed afterwards.

Each group's divided clock comes in as a phase level on `phase_in`. Index 0 is CPU, then 1 memory reference, 2 APIC, 3 66 MHz, 4 PCI (33 MHz), 5 USB (48 MHz) and 6 reference. A gated output equals its phase ANDed with a gate enable. That enable is updated only on clock edges where the phase is low.

Top module: `clk_pd_ctrl`

## Requirements
- R1: After `pd_req_n` goes low, every one of the 25 clock outputs is low and stays low before two full PCI periods (two rising PCI phase edges after the first) have passed. The request passes through a SYNC_STAGES flop synchronizer first.
- R2: Once all groups are parked, `osc_en` and `pll_en` drop to 0. While `osc_en` is 0, every clock output is low.
- R3: A gate enable changes only while its group phase is low. No output shows a high pulse shorter than its phase, and no output rises except together with its phase.
- R4: When the request is released, `osc_en` and `pll_en` return to 1 within SYNC_STAGES+1 cycles. No clock output goes high until at least WAKE_CYCLES cycles after `osc_en` rose. After that, the outputs run again.
- R5: A request asserted during the restart wait cancels it. `osc_en` and `pll_en` return to 0 and the outputs stay low.
- R6: `ref_oe` is 0 from reset through the first STRAP_CYCLES cycles. It then becomes 1 and never falls again until the next reset.
- R7: At the end of the sampling window, `apic_div4` takes `strap_pad[0]` (1 = APIC at CPU/4, 0 = fixed 16.667 MHz). `test_mode` takes the inverse of `strap_pad[1]` (pad low = test). Later pad changes and power-down cycles leave both unchanged.
- R8: With `wide_sel` low at power-up, `cpu_clk[6:5]` and `apic_clk[6:5]` stay low and all other outputs run. With it high, all outputs run.
- R9: A change of `wide_sel` after initialization enables or disables the upper CPU and APIC outputs while running.
- R10: During reset all clock outputs and `ref_oe` are 0, `osc_en`/`pll_en` are 1, and `apic_div4`/`test_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| wide_sel | input | 1 | 1 = all upper CPU/APIC outputs on, 0 = upper two of each off |
| strap_pad | input | 2 | Pad levels: bit 0 APIC speed strap, bit 1 active-low test strap |
| phase_in | input | 7 | Divided clock phase per group |
| cpu_clk | output | N_CPU | Gated CPU clocks |
| mem_clk | output | N_MEM | Gated memory reference clocks |
| apic_clk | output | N_APIC | Gated APIC clocks |
| f66_clk | output | N_F66 | Gated 66 MHz clocks |
| pci_clk | output | N_F33 | Gated 33 MHz clocks |
| usb_clk | output | 1 | Gated 48 MHz clock |
| ref_clk | output | 2 | Gated reference clocks for the shared pads |
| ref_oe | output | 1 | Pad drive enable for the reference outputs |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| apic_div4 | output | 1 | Latched APIC speed strap |
| test_mode | output | 1 | Latched test-mode strap |

## Verification
The request reaches the sequencer SYNC_STAGES+1 cycles after it changes. The outputs then park within half of the slowest group period. The oscillator enable follows one cycle after the last gate closes. Outputs resume no earlier than WAKE_CYCLES+1 cycles after the release reaches the sequencer. The latched straps and `ref_oe` are fixed STRAP_CYCLES cycles after reset. For these reasons the scoreboard does not compare outputs at a single edge. Instead it clears an activity mask at one cycle and compares it at a later one. Each window is placed clear of those latencies and lies fully before or after the moment the result is due. Level outputs such as `osc_en` are compared at cycles chosen several cycles past their latency.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic [2:0] {
        ST_STRAP,
        ST_WAKE,
        ST_RUN,
        ST_STOP,
        ST_OFF
    } pd_state_e;

    localparam int N_PHASE = 7;
    localparam int PH_CPU  = 0;
    localparam int PH_MEM  = 1;
    localparam int PH_APIC = 2;
    localparam int PH_F66  = 3;
    localparam int PH_F33  = 4;
    localparam int PH_USB  = 5;
    localparam int PH_REF  = 6;

    localparam int N_REF   = 2;

    localparam int N_GATE     = 9;
    localparam int GT_CPU_LO  = 0;
    localparam int GT_CPU_HI  = 1;
    localparam int GT_MEM     = 2;
    localparam int GT_APIC_LO = 3;
    localparam int GT_APIC_HI = 4;
    localparam int GT_F66     = 5;
    localparam int GT_F33     = 6;
    localparam int GT_USB     = 7;
    localparam int GT_REF     = 8;

    typedef struct packed {
        logic apic_div4;
        logic test_mode;
    } strap_t;

    function automatic int gate_phase(input int g);
        case (g)
            GT_CPU_LO, GT_CPU_HI:   return PH_CPU;
            GT_MEM:                 return PH_MEM;
            GT_APIC_LO, GT_APIC_HI: return PH_APIC;
            GT_F66:                 return PH_F66;
            GT_F33:                 return PH_F33;
            GT_USB:                 return PH_USB;
            default:                return PH_REF;
        endcase
    endfunction

    function automatic bit gate_is_upper(input int g);
        return (g == GT_CPU_HI) || (g == GT_APIC_HI);
    endfunction

endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cpd_gate.sv
module cpd_gate (
    input  logic clk,
    input  logic rst,
    input  logic phase,
    input  logic want,
    output logic en,
    output logic gclk
);
    // enable moves only while the phase is low: no runt pulses
    always_ff @(posedge clk) begin
        if (rst)        en <= 1'b0;
        else if (!phase) en <= want;
    end

    assign gclk = phase & en;
endmodule

// File: rtl/cpd_seq.sv
module cpd_seq
    import cpd_pkg::*;
#(
    parameter int STRAP_CYCLES = 16,
    parameter int WAKE_CYCLES  = 42955
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_req,
    input  logic            wide_s,
    input  logic [N_REF-1:0] pads,
    input  logic            all_off,
    output logic            run_want,
    output logic            upper_want,
    output strap_t          straps,
    output logic            ref_oe,
    output logic            osc_en,
    output logic            pll_en
);
    localparam int CNT_MAX = (STRAP_CYCLES > WAKE_CYCLES) ? STRAP_CYCLES : WAKE_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);

    pd_state_e     st, st_nx;
    logic [CW-1:0] cnt;
    logic          strap_last;
    logic          wide_q;

    assign strap_last = (st == ST_STRAP) && (cnt == CW'(STRAP_CYCLES - 1));

    always_comb begin
        st_nx = st;
        case (st)
            ST_STRAP: if (strap_last) st_nx = run_req ? ST_WAKE : ST_OFF;
            ST_WAKE: begin
                if (!run_req)                         st_nx = ST_OFF;
                else if (cnt == CW'(WAKE_CYCLES - 1)) st_nx = ST_RUN;
            end
            ST_RUN:  if (!run_req) st_nx = ST_STOP;
            ST_STOP: if (all_off)  st_nx = ST_OFF;
            ST_OFF:  if (run_req)  st_nx = ST_WAKE;
            default: st_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_STRAP;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st_nx != st)                        cnt <= '0;
            else if (st == ST_STRAP || st == ST_WAKE) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            straps <= '0;
            ref_oe <= 1'b0;
            wide_q <= 1'b1;
        end else begin
            if (strap_last) begin
                straps.apic_div4 <= pads[0];
                straps.test_mode <= ~pads[1];
                ref_oe           <= 1'b1;
            end
            if (st != ST_STRAP || strap_last) wide_q <= wide_s;
        end
    end

    assign run_want   = (st == ST_RUN);
    assign upper_want = run_want & wide_q;
    assign osc_en     = (st != ST_OFF);
    assign pll_en     = (st != ST_OFF);
endmodule

// File: rtl/clk_pd_ctrl.sv
module clk_pd_ctrl
    import cpd_pkg::*;
#(
    parameter int N_CPU        = 7,
    parameter int N_MEM        = 2,
    parameter int N_APIC       = 7,
    parameter int N_F66        = 4,
    parameter int N_F33        = 2,
    parameter int N_UPPER      = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int STRAP_CYCLES = 16,
    parameter int WAKE_CYCLES  = 42955
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pd_req_n,
    input  logic               wide_sel,
    input  logic [N_REF-1:0]   strap_pad,
    input  logic [N_PHASE-1:0] phase_in,
    output logic [N_CPU-1:0]   cpu_clk,
    output logic [N_MEM-1:0]   mem_clk,
    output logic [N_APIC-1:0]  apic_clk,
    output logic [N_F66-1:0]   f66_clk,
    output logic [N_F33-1:0]   pci_clk,
    output logic               usb_clk,
    output logic [N_REF-1:0]   ref_clk,
    output logic               ref_oe,
    output logic               osc_en,
    output logic               pll_en,
    output logic               apic_div4,
    output logic               test_mode
);
    localparam int N_CPU_LO  = N_CPU - N_UPPER;
    localparam int N_APIC_LO = N_APIC - N_UPPER;

    logic        run_s, wide_s;
    logic        run_want, upper_want, all_off;
    strap_t      straps;
    logic [N_GATE-1:0] gate_want, gate_en, gate_on;

    cpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pd (
        .clk(clk), .rst(rst), .d(pd_req_n), .q(run_s)
    );

    cpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wide (
        .clk(clk), .rst(rst), .d(wide_sel), .q(wide_s)
    );

    cpd_seq #(.STRAP_CYCLES(STRAP_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .run_req(run_s), .wide_s(wide_s), .pads(strap_pad),
        .all_off(all_off), .run_want(run_want), .upper_want(upper_want),
        .straps(straps), .ref_oe(ref_oe), .osc_en(osc_en), .pll_en(pll_en)
    );

    always_comb begin
        for (int g = 0; g < N_GATE; g++)
            gate_want[g] = gate_is_upper(g) ? upper_want : run_want;
    end

    generate
        for (genvar g = 0; g < N_GATE; g++) begin : g_gate
            cpd_gate u_gate (
                .clk(clk), .rst(rst), .phase(phase_in[gate_phase(g)]),
                .want(gate_want[g]), .en(gate_en[g]), .gclk(gate_on[g])
            );
        end
    endgenerate

    assign all_off = ~|gate_en;

    assign cpu_clk   = {{N_UPPER{gate_on[GT_CPU_HI]}},  {N_CPU_LO{gate_on[GT_CPU_LO]}}};
    assign apic_clk  = {{N_UPPER{gate_on[GT_APIC_HI]}}, {N_APIC_LO{gate_on[GT_APIC_LO]}}};
    assign mem_clk   = {N_MEM{gate_on[GT_MEM]}};
    assign f66_clk   = {N_F66{gate_on[GT_F66]}};
    assign pci_clk   = {N_F33{gate_on[GT_F33]}};
    assign usb_clk   = gate_on[GT_USB];
    assign ref_clk   = {N_REF{gate_on[GT_REF]}};
    assign apic_div4 = straps.apic_div4;
    assign test_mode = straps.test_mode;
endmodule

// File: rtl/cpd_chk.sv
module cpd_chk
    import cpd_pkg::*;
#(
    parameter int N_CPU       = 7,
    parameter int N_MEM       = 2,
    parameter int N_APIC      = 7,
    parameter int N_F66       = 4,
    parameter int N_F33       = 2,
    parameter int WAKE_CYCLES = 42955
) (
    input logic               clk,
    input logic               rst,
    input logic               pd_req_n,
    input logic [N_PHASE-1:0] phase_in,
    input logic [N_CPU-1:0]   cpu_clk,
    input logic [N_MEM-1:0]   mem_clk,
    input logic [N_APIC-1:0]  apic_clk,
    input logic [N_F66-1:0]   f66_clk,
    input logic [N_F33-1:0]   pci_clk,
    input logic               usb_clk,
    input logic [N_REF-1:0]   ref_clk,
    input logic               ref_oe,
    input logic               osc_en,
    input logic               apic_div4,
    input logic               test_mode
);
    logic any_out;
    assign any_out = |{ref_clk, usb_clk, pci_clk, f66_clk, apic_clk, mem_clk, cpu_clk};

    logic [31:0] osc_on_cnt;
    always_ff @(posedge clk) begin
        if (rst || !osc_en)                   osc_on_cnt <= '0;
        else if (osc_on_cnt < WAKE_CYCLES)    osc_on_cnt <= osc_on_cnt + 1;
    end

    logic       pci_prev;
    logic [2:0] pci_rises;
    always_ff @(posedge clk) begin
        if (rst) begin
            pci_prev  <= 1'b0;
            pci_rises <= '0;
        end else begin
            pci_prev <= phase_in[PH_F33];
            if (pd_req_n)                                          pci_rises <= '0;
            else if (phase_in[PH_F33] && !pci_prev && pci_rises != 3'd7) pci_rises <= pci_rises + 1'b1;
        end
    end

    // R1
    stop_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (pci_rises >= 3'd3) |-> !any_out);

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> !any_out);

    // R3
    cpu_no_runt_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_in[PH_CPU] && $past(phase_in[PH_CPU]) && $past(cpu_clk[0])) |-> cpu_clk[0]);

    // R3
    ref_no_runt_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_in[PH_REF] && $past(phase_in[PH_REF]) && $past(ref_clk[0])) |-> ref_clk[0]);

    // R3
    apic_hi_no_runt_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_in[PH_APIC] && $past(phase_in[PH_APIC]) && $past(apic_clk[N_APIC-1])) |-> apic_clk[N_APIC-1]);

    // R3
    pci_clean_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pci_clk[0]) |-> $rose(phase_in[PH_F33]));

    // R3
    usb_clean_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(usb_clk) |-> $rose(phase_in[PH_USB]));

    // R4
    wake_wait_chk: assert property (@(posedge clk) disable iff (rst)
        any_out |-> (osc_on_cnt >= WAKE_CYCLES));

    // R6
    ref_oe_keep_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ref_oe) |-> ref_oe);

    // R7
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ref_oe) |-> $stable({apic_div4, test_mode}));
endmodule

bind clk_pd_ctrl cpd_chk #(
    .N_CPU(N_CPU), .N_MEM(N_MEM), .N_APIC(N_APIC), .N_F66(N_F66), .N_F33(N_F33),
    .WAKE_CYCLES(WAKE_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .pd_req_n(pd_req_n), .phase_in(phase_in),
    .cpu_clk(cpu_clk), .mem_clk(mem_clk), .apic_clk(apic_clk), .f66_clk(f66_clk),
    .pci_clk(pci_clk), .usb_clk(usb_clk), .ref_clk(ref_clk), .ref_oe(ref_oe),
    .osc_en(osc_en), .apic_div4(apic_div4), .test_mode(test_mode)
);

// File: tb/clk_pd_ctrl_tb.sv
module clk_pd_ctrl_tb;
    import cpd_pkg::*;

    localparam logic [24:0] FULL   = 25'h1FFFFFF;
    localparam logic [24:0] NARROW = 25'h1FF3F9F; // cpu[6:5] (bits 6:5), apic[6:5] (bits 15:14) off

    localparam int SEL_CLR = 0, SEL_ACT = 1, SEL_OSC = 2, SEL_PLL = 3,
                   SEL_OE = 4, SEL_APIC = 5, SEL_TEST = 6;

    typedef struct {
        int          due;
        int          sel;
        logic [24:0] exp;
        string       req;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_req_n = 1'b1;
    logic wide_sel = 1'b0;
    logic [1:0] strap_pad = 2'b10;
    logic [N_PHASE-1:0] phase_in = '0;

    logic [6:0] cpu_clk, apic_clk;
    logic [1:0] mem_clk, pci_clk, ref_clk;
    logic [3:0] f66_clk;
    logic usb_clk, ref_oe, osc_en, pll_en, apic_div4, test_mode;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    sb_item_t sb_q[$];
    logic [24:0] act = '0;

    always #2 clk = ~clk;

    clk_pd_ctrl #(.SYNC_STAGES(2), .STRAP_CYCLES(8), .WAKE_CYCLES(40)) u_dut (
        .clk(clk), .rst(rst), .pd_req_n(pd_req_n), .wide_sel(wide_sel),
        .strap_pad(strap_pad), .phase_in(phase_in), .cpu_clk(cpu_clk),
        .mem_clk(mem_clk), .apic_clk(apic_clk), .f66_clk(f66_clk),
        .pci_clk(pci_clk), .usb_clk(usb_clk), .ref_clk(ref_clk), .ref_oe(ref_oe),
        .osc_en(osc_en), .pll_en(pll_en), .apic_div4(apic_div4), .test_mode(test_mode)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [24:0] observe(input int sel);
        case (sel)
            SEL_ACT:  return act;
            SEL_OSC:  return {24'd0, osc_en};
            SEL_PLL:  return {24'd0, pll_en};
            SEL_OE:   return {24'd0, ref_oe};
            SEL_APIC: return {24'd0, apic_div4};
            SEL_TEST: return {24'd0, test_mode};
            default:  return '0;
        endcase
    endfunction

    // monitor: sample outputs, score due items, then advance the phases
    always @(negedge clk) begin
        logic [24:0] got;
        act = act | {ref_clk, usb_clk, pci_clk, f66_clk, apic_clk, mem_clk, cpu_clk};
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                if (sb_q[i].sel == SEL_CLR) begin
                    act = '0;
                end else begin
                    got = observe(sb_q[i].sel);
                    checks++;
                    if (got !== sb_q[i].exp) begin
                        errors++;
                        $display("FAIL %s cyc=%0d sel=%0d actual=%h expected=%h",
                                 sb_q[i].req, cyc, sb_q[i].sel, got, sb_q[i].exp);
                    end
                end
                sb_q.delete(i);
            end
        end
        phase_in[PH_CPU]  = ((cyc / 1) % 2) == 1;
        phase_in[PH_MEM]  = ((cyc / 2) % 2) == 1;
        phase_in[PH_APIC] = ((cyc / 4) % 2) == 1;
        phase_in[PH_F66]  = ((cyc / 3) % 2) == 1;
        phase_in[PH_F33]  = ((cyc / 4) % 2) == 1;
        phase_in[PH_USB]  = ((cyc / 5) % 2) == 1;
        phase_in[PH_REF]  = ((cyc / 6) % 2) == 1;
    end

    task automatic expect_at(input int due, input int sel, input logic [24:0] exp, input string req);
        sb_item_t it;
        it.due = due; it.sel = sel; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic window(input int from, input int to, input logic [24:0] exp, input string req);
        expect_at(from, SEL_CLR, '0, req);
        expect_at(to, SEL_ACT, exp, req);
    endtask

    task automatic drive_at(input int n);
        while (cyc < n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        // R10 reset state
        window(1, 3, '0, "R10");
        expect_at(2, SEL_OE, 25'd0, "R10");
        expect_at(2, SEL_OSC, 25'd1, "R10");
        expect_at(2, SEL_PLL, 25'd1, "R10");
        expect_at(2, SEL_APIC, 25'd0, "R10");
        expect_at(2, SEL_TEST, 25'd0, "R10");
        // R6 strap window then drive
        expect_at(8, SEL_OE, 25'd0, "R6");
        expect_at(20, SEL_OE, 25'd1, "R6");
        // R4 nothing toggles during first restart wait
        window(14, 48, '0, "R4");
        // R7 pads changed after window are ignored
        expect_at(30, SEL_APIC, 25'd0, "R7");
        expect_at(30, SEL_TEST, 25'd0, "R7");
        // R8 narrow configuration
        window(70, 110, NARROW, "R8");
        // R9 widen while running
        window(125, 165, FULL, "R9");
        // R1 parked within two PCI periods, R2 oscillator off
        window(186, 200, '0, "R1");
        expect_at(200, SEL_OSC, 25'd0, "R2");
        expect_at(200, SEL_PLL, 25'd0, "R2");
        // R4 release turns oscillator on; R5 abort turns it off again
        expect_at(230, SEL_OSC, 25'd1, "R4");
        expect_at(250, SEL_OSC, 25'd0, "R5");
        expect_at(250, SEL_PLL, 25'd0, "R5");
        window(225, 290, '0, "R5");
        // R4 full restart
        expect_at(310, SEL_PLL, 25'd1, "R4");
        window(305, 338, '0, "R4");
        window(360, 400, FULL, "R4");
        expect_at(400, SEL_APIC, 25'd0, "R7");
        expect_at(400, SEL_TEST, 25'd0, "R7");
        expect_at(400, SEL_OE, 25'd1, "R6");
        // R9 narrow while running
        window(430, 470, NARROW, "R9");
        // R7 / R8 second power-up with other strap values
        expect_at(520, SEL_APIC, 25'd1, "R7");
        expect_at(520, SEL_TEST, 25'd1, "R7");
        window(560, 600, FULL, "R8");

        drive_at(4);   rst = 1'b0;
        drive_at(25);  strap_pad = 2'b01;
        drive_at(110); wide_sel = 1'b1;
        drive_at(170); pd_req_n = 1'b0;
        drive_at(220); pd_req_n = 1'b1;
        drive_at(240); pd_req_n = 1'b0;
        drive_at(300); pd_req_n = 1'b1;
        drive_at(410); wide_sel = 1'b0;
        drive_at(480); rst = 1'b1; wide_sel = 1'b1; strap_pad = 2'b01;
        drive_at(485); rst = 1'b0;
        drive_at(620);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard items left=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog cyc=%0d expected end by 620", cyc);
        finish_run();
    end
endmodule